// File: doc/BRIEF.md
# Segment Descriptor Cache and Access Checker

This block keeps the hidden half of one protected-mode segment register. When a new selector is loaded, it splits the selector into a table index, a table choice and a requested privilege level. It then reads the 8-byte descriptor from the chosen table through a simple read port and stores the decoded base, the effective limit and the attribute byte. While the fetch is in progress, the block reports that it is busy.

After a load completes, every memory access against the segment uses only the stored copy. The block adds the access offset to the stored base to form the linear address. It flags a protection fault when the offset goes past the limit or when a write targets a segment that does not allow writes. The descriptor table in memory is never read again until the next load, so later changes to the table have no effect on the stored copy.

Top module: `segDescCache`

## Requirements
- R1: After reset `busy` and `segValid` are low, and any access made before a successful load returns `accFault` high one cycle later.
- R2: The selector is decoded as index = bits [15:3], table choice = bit 2 (0 picks the global table base/limit inputs, 1 picks the local ones), requested privilege = bits [1:0]. After a successful load, `segRpl` shows that privilege value.
- R3: A load issues exactly two 32-bit reads, first at tableBase + 8*index and then at tableBase + 8*index + 4. The low word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word holds base[23:16] in bits 7:0, the attribute byte in bits 15:8, limit[19:16] in bits 19:16, the granularity flag in bit 23 and base[31:24] in bits 31:24.
- R4: `busy` is high from the cycle after a load is accepted (`ldValid` while idle) up to and including the one-cycle `ldDone` pulse, and it is low in the cycle after `ldDone`. A `ldValid` seen while busy is ignored.
- R5: If 8*index + 7 exceeds the chosen table limit, the load ends with `ldDone` and `ldFault` high, issues no read, and leaves the stored segment unchanged.
- R6: An access (`accValid`) returns `accRspValid` one cycle later, with `accLinAddr` = stored base + offset.
- R7: With the granularity flag clear, the limit is byte granular: offset == limit passes and offset == limit+1 faults.
- R8: With the granularity flag set, the effective limit is (limit << 12) | 0xFFF.
- R9: A write faults when the attribute byte's bit 3 is set (code segment) or its bit 1 is clear (read-only data). Reads to such segments do not fault for this reason.
- R10: Accesses never issue a table read. Changing table memory after a load does not change the stored base, limit or rights.
- R11: A read request holds its address and `memRdValid` until `memRdReady` is seen, and the data is taken in the cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Request to load a new selector |
| ldSelector | input | SEL_W | Selector being loaded |
| gdtBase | input | 32 | Global table base address |
| gdtLimit | input | TLIM_W | Global table limit in bytes |
| ldtBase | input | 32 | Local table base address |
| ldtLimit | input | TLIM_W | Local table limit in bytes |
| busy | output | 1 | Load in progress |
| ldDone | output | 1 | One-cycle load completion pulse |
| ldFault | output | 1 | Load failed (valid with ldDone) |
| memRdValid | output | 1 | Table read request |
| memRdReady | input | 1 | Read accepted; data valid this cycle |
| memRdAddr | output | 32 | Table read byte address |
| memRdData | input | 32 | Table read data |
| accValid | input | 1 | Access request |
| accOffset | input | 32 | Access offset within the segment |
| accWrite | input | 1 | Access is a write |
| accRspValid | output | 1 | Access result valid |
| accLinAddr | output | 32 | Linear address of the access |
| accFault | output | 1 | Protection fault on the access |
| segValid | output | 1 | A descriptor is stored |
| segRpl | output | 2 | Requested privilege of the stored selector |

## Verification
The bench loads segments from both tables, using a byte-granular writable data descriptor, a page-granular read-only data descriptor and a code descriptor. The read addresses show whether the table choice and the index were decoded correctly. For each segment, accesses are made at the limit and one byte past it, which separates byte scaling from page scaling. Writes and reads to each segment type separate the rights checks from the limit checks. A load that overruns the table must leave the previous segment usable, and rewriting the table after a load must not change later results. A stalled read port and a load request made while busy test the handshake and the rule that such requests are ignored.

// File: rtl/segcache_pkg.sv
package segcache_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int RAW_LIM_W = 20;
  localparam int PAGE_SH = 12;

  // attribute byte bit positions
  localparam int ATTR_CODE = 3;
  localparam int ATTR_WR = 1;

  typedef struct packed {
    logic latchSel;
    logic capLow;
    logic commit;
    logic hiWord;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RD_LO, S_RD_HI, S_DONE
  } ldState_t;

  function automatic logic [ADDR_W-1:0] scaleLimit(
      input logic [RAW_LIM_W-1:0] raw, input logic gran);
    if (gran) scaleLimit = {raw, {PAGE_SH{1'b1}}};
    else scaleLimit = {{(ADDR_W-RAW_LIM_W){1'b0}}, raw};
  endfunction
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ldValid,
  input  logic      tableOverrun,
  input  logic      memRdReady,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      memRdValid,
  output logic      ldDone,
  output logic      ldFault
);
  ldState_t state, stateNxt;
  logic faultQ;

  always_comb begin
    stateNxt = state;
    strobe = '0;
    memRdValid = 1'b0;
    unique case (state)
      S_IDLE: if (ldValid) begin
        strobe.latchSel = 1'b1;
        stateNxt = S_CHECK;
      end
      S_CHECK: stateNxt = tableOverrun ? S_DONE : S_RD_LO;
      S_RD_LO: begin
        memRdValid = 1'b1;
        if (memRdReady) begin
          strobe.capLow = 1'b1;
          stateNxt = S_RD_HI;
        end
      end
      S_RD_HI: begin
        memRdValid = 1'b1;
        strobe.hiWord = 1'b1;
        if (memRdReady) begin
          strobe.commit = 1'b1;
          stateNxt = S_DONE;
        end
      end
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      faultQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && ldValid) faultQ <= 1'b0;
      else if (state == S_CHECK && tableOverrun) faultQ <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign ldDone = (state == S_DONE);
  assign ldFault = ldDone & faultQ;
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segcache_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SEL_W-1:0]  ldSelector,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [TLIM_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [TLIM_W-1:0] ldtLimit,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accOffset,
  input  logic              accWrite,
  output logic              tableOverrun,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              segValid,
  output logic [1:0]        segRpl,
  output logic              accRspValid,
  output logic [ADDR_W-1:0] accLinAddr,
  output logic              accFault
);
  localparam int IDX_W = SEL_W - 3;
  localparam int OFS_W = IDX_W + 3;
  localparam int CMP_W = (OFS_W > TLIM_W) ? OFS_W : TLIM_W;

  logic [IDX_W-1:0]  selIdx;
  logic [1:0]        selRpl;
  logic [ADDR_W-1:0] tblBase;
  logic [TLIM_W-1:0] tblLimit;
  logic [WORD_W-1:0] lowWord;

  logic [ADDR_W-1:0] cBase;
  logic [ADDR_W-1:0] cLimit;
  logic [7:0]        cAttr;
  logic [1:0]        cRpl;
  logic              cValid;

  // descriptor field extraction (low word captured, high word live)
  logic [ADDR_W-1:0]    newBase;
  logic [RAW_LIM_W-1:0] newRawLim;
  logic                 newGran;
  logic [7:0]           newAttr;
  assign newBase   = {memRdData[31:24], memRdData[7:0], lowWord[31:16]};
  assign newRawLim = {memRdData[19:16], lowWord[15:0]};
  assign newGran   = memRdData[23];
  assign newAttr   = memRdData[15:8];

  logic [CMP_W-1:0] lastByte, limWide;
  assign lastByte = CMP_W'({selIdx, 3'b111});
  assign limWide  = CMP_W'(tblLimit);
  assign tableOverrun = lastByte > limWide;

  assign memRdAddr = tblBase + ADDR_W'({selIdx, 3'b000})
                   + (strobe.hiWord ? ADDR_W'(4) : ADDR_W'(0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx <= '0;
      selRpl <= '0;
      tblBase <= '0;
      tblLimit <= '0;
      lowWord <= '0;
    end else begin
      if (strobe.latchSel) begin
        selIdx <= ldSelector[SEL_W-1:3];
        selRpl <= ldSelector[1:0];
        tblBase <= ldSelector[2] ? ldtBase : gdtBase;
        tblLimit <= ldSelector[2] ? ldtLimit : gdtLimit;
      end
      if (strobe.capLow) lowWord <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cBase <= '0;
      cLimit <= '0;
      cAttr <= '0;
      cRpl <= '0;
      cValid <= 1'b0;
    end else if (strobe.commit) begin
      cBase <= newBase;
      cLimit <= scaleLimit(newRawLim, newGran);
      cAttr <= newAttr;
      cRpl <= selRpl;
      cValid <= 1'b1;
    end
  end

  logic writeOk, overLimit, faultNow;
  assign writeOk = !cAttr[ATTR_CODE] && cAttr[ATTR_WR];
  assign overLimit = accOffset > cLimit;
  assign faultNow = !cValid || overLimit || (accWrite && !writeOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accRspValid <= 1'b0;
      accLinAddr <= '0;
      accFault <= 1'b0;
    end else begin
      accRspValid <= accValid;
      if (accValid) begin
        accLinAddr <= cBase + accOffset;
        accFault <= faultNow;
      end
    end
  end

  assign segValid = cValid;
  assign segRpl = cRpl;
endmodule

// File: rtl/segDescCache.sv
module segDescCache
  import segcache_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int TLIM_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [SEL_W-1:0]  ldSelector,
  input  logic [31:0]       gdtBase,
  input  logic [TLIM_W-1:0] gdtLimit,
  input  logic [31:0]       ldtBase,
  input  logic [TLIM_W-1:0] ldtLimit,
  output logic              busy,
  output logic              ldDone,
  output logic              ldFault,
  output logic              memRdValid,
  input  logic              memRdReady,
  output logic [31:0]       memRdAddr,
  input  logic [31:0]       memRdData,
  input  logic              accValid,
  input  logic [31:0]       accOffset,
  input  logic              accWrite,
  output logic              accRspValid,
  output logic [31:0]       accLinAddr,
  output logic              accFault,
  output logic              segValid,
  output logic [1:0]        segRpl
);
  dpStrobe_t strobe;
  logic tableOverrun;

  segCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid),
    .tableOverrun(tableOverrun), .memRdReady(memRdReady),
    .strobe(strobe), .busy(busy), .memRdValid(memRdValid),
    .ldDone(ldDone), .ldFault(ldFault)
  );

  segDatapath #(.SEL_W(SEL_W), .TLIM_W(TLIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ldSelector(ldSelector),
    .gdtBase(gdtBase), .gdtLimit(gdtLimit), .ldtBase(ldtBase),
    .ldtLimit(ldtLimit), .memRdData(memRdData), .accValid(accValid),
    .accOffset(accOffset), .accWrite(accWrite),
    .tableOverrun(tableOverrun), .memRdAddr(memRdAddr),
    .segValid(segValid), .segRpl(segRpl), .accRspValid(accRspValid),
    .accLinAddr(accLinAddr), .accFault(accFault)
  );
endmodule

// File: rtl/segCacheChecker.sv
module segCacheChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        ldDone,
  input logic        ldFault,
  input logic        memRdValid,
  input logic        memRdReady,
  input logic [31:0] memRdAddr,
  input logic        accValid,
  input logic        accRspValid,
  input logic        accFault,
  input logic        segValid,
  input logic [1:0]  segRpl
);
  p_read_needs_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> busy);

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> (memRdValid && $stable(memRdAddr)));

  p_done_releases_r4: assert property (@(posedge clk) disable iff (!rstN)
    ldDone |=> (!busy && !ldDone));

  p_acc_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> accRspValid);

  p_empty_fault_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !segValid) |=> accFault);

  p_fault_keeps_cache_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ldDone && ldFault) |-> ($stable(segValid) && $stable(segRpl)));
endmodule

bind segDescCache segCacheChecker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .ldDone(ldDone), .ldFault(ldFault),
  .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
  .accValid(accValid), .accRspValid(accRspValid), .accFault(accFault),
  .segValid(segValid), .segRpl(segRpl)
);

// File: tb/test_segDescCache.sv
`timescale 1ns/1ps
module test_segDescCache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        ldValid = 1'b0;
  logic [15:0] ldSelector = '0;
  logic [31:0] gdtBase = 32'h100, ldtBase = 32'h200;
  logic [15:0] gdtLimit = 16'h001F, ldtLimit = 16'h00FF;
  logic busy, ldDone, ldFault, memRdValid, memRdReady;
  logic [31:0] memRdAddr, memRdData;
  logic        accValid = 1'b0;
  logic [31:0] accOffset = '0;
  logic        accWrite = 1'b0;
  logic accRspValid, accFault, segValid;
  logic [31:0] accLinAddr;
  logic [1:0] segRpl;

  segDescCache i_segDescCache (.*);

  // memory model with optional stall
  logic [31:0] mem [1024];
  logic stallMode = 1'b0;
  int stallCnt = 0;
  assign memRdReady = stallMode ? (stallCnt == 2) : 1'b1;
  assign memRdData = mem[memRdAddr[11:2]];

  int readCnt = 0;
  logic [31:0] readAddr [8];
  always @(posedge clk) begin
    if (memRdValid && memRdReady) begin
      if (readCnt < 8) readAddr[readCnt] <= memRdAddr;
      readCnt <= readCnt + 1;
      stallCnt <= 0;
    end else if (memRdValid) stallCnt <= stallCnt + 1;
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putDesc(input logic [31:0] addr, input logic [31:0] base,
                         input logic [19:0] lim, input logic [7:0] attr,
                         input logic gran);
    mem[addr[11:2]] = {base[15:0], lim[15:0]};
    mem[addr[11:2] + 1] = {base[31:24], gran, 3'b100, lim[19:16], attr, base[23:16]};
  endtask

  // scoreboard
  typedef struct packed { logic [31:0] addr; logic fault; logic chkAddr; } exp_t;
  exp_t expQ[$];
  string tagQ[$];

  task automatic doAccess(input logic [31:0] ofs, input logic wr,
                          input logic [31:0] expAddr, input logic expFault,
                          input logic chkAddr, input string tag);
    @(negedge clk);
    accValid = 1'b1; accOffset = ofs; accWrite = wr;
    expQ.push_back('{expAddr, expFault, chkAddr});
    tagQ.push_back(tag);
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  always @(negedge clk) begin
    if (accRspValid) begin
      if (expQ.size() == 0) check(1'b0, "scoreboard-empty", 32'h0, 32'h0);
      else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(accFault == e.fault, {t, " fault"}, {31'b0, accFault}, {31'b0, e.fault});
        if (e.chkAddr && !e.fault)
          check(accLinAddr == e.addr, {t, " addr"}, accLinAddr, e.addr);
      end
    end
  end

  task automatic loadSeg(input logic [15:0] sel, output logic fault,
                         input bit pokeBusy);
    @(negedge clk);
    ldValid = 1'b1; ldSelector = sel;
    @(negedge clk);
    ldValid = 1'b0;
    check(busy == 1'b1, "R4 busy after accept", {31'b0, busy}, 32'h1);
    if (pokeBusy) begin
      ldValid = 1'b1; ldSelector = 16'h0020;
      @(negedge clk);
      ldValid = 1'b0;
    end
    while (!ldDone) @(negedge clk);
    fault = ldFault;
    @(negedge clk);
    check(busy == 1'b0, "R4 busy drops after done", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic f;
    int rc;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    putDesc(32'h110, 32'h12345000, 20'h00FFF, 8'h92, 1'b0); // gdt idx2 rw data
    putDesc(32'h118, 32'h00ABC000, 20'h000FF, 8'h9A, 1'b0); // gdt idx3 code
    putDesc(32'h208, 32'h00400000, 20'h00002, 8'h90, 1'b1); // ldt idx1 ro, pages
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy at reset", {31'b0, busy}, 32'h0);
    check(segValid == 1'b0, "R1 segValid at reset", {31'b0, segValid}, 32'h0);
    doAccess(32'h0, 1'b0, 32'h0, 1'b1, 1'b0, "R1 access before load");

    // global table, idx2, rpl3, with a load request poked while busy
    rc = readCnt;
    loadSeg(16'h0013, f, 1'b1);
    check(f == 1'b0, "R2 gdt load ok", {31'b0, f}, 32'h0);
    check(segRpl == 2'd3, "R2 rpl", {30'b0, segRpl}, 32'h3);
    check(readCnt - rc == 2, "R3/R4 two reads only", readCnt - rc, 32'd2);
    check(readAddr[rc] == 32'h110, "R3 low word addr", readAddr[rc], 32'h110);
    check(readAddr[rc+1] == 32'h114, "R3 high word addr", readAddr[rc+1], 32'h114);
    check(segValid == 1'b1, "R2 segValid", {31'b0, segValid}, 32'h1);
    doAccess(32'h10, 1'b0, 32'h12345010, 1'b0, 1'b1, "R6 linear addr");
    doAccess(32'hFFF, 1'b0, 32'h12345FFF, 1'b0, 1'b1, "R7 at limit");
    doAccess(32'h1000, 1'b0, 32'h0, 1'b1, 1'b0, "R7 past limit");
    doAccess(32'h20, 1'b1, 32'h12345020, 1'b0, 1'b1, "R9 write rw data");

    // R10: rewrite table, cached copy must remain
    rc = readCnt;
    putDesc(32'h110, 32'h77770000, 20'h00000, 8'h90, 1'b0);
    doAccess(32'h800, 1'b1, 32'h12345800, 1'b0, 1'b1, "R10 cache reused");
    repeat (2) @(negedge clk);
    check(readCnt == rc, "R10 no reads on access", readCnt, rc);

    // local table, idx1, rpl1, page granular read-only
    rc = readCnt;
    loadSeg(16'h000D, f, 1'b0);
    check(f == 1'b0, "R2 ldt load ok", {31'b0, f}, 32'h0);
    check(readAddr[rc] == 32'h208, "R2 ldt table chosen", readAddr[rc], 32'h208);
    check(segRpl == 2'd1, "R2 ldt rpl", {30'b0, segRpl}, 32'h1);
    doAccess(32'h2FFF, 1'b0, 32'h00402FFF, 1'b0, 1'b1, "R8 page limit edge");
    doAccess(32'h3000, 1'b0, 32'h0, 1'b1, 1'b0, "R8 past page limit");
    doAccess(32'h0, 1'b1, 32'h0, 1'b1, 1'b0, "R9 write read-only");
    doAccess(32'h4, 1'b0, 32'h00400004, 1'b0, 1'b1, "R9 read read-only");

    // code segment with stalled read port, idx3 at table edge
    stallMode = 1'b1;
    rc = readCnt;
    loadSeg(16'h0018, f, 1'b0);
    stallMode = 1'b0;
    check(f == 1'b0, "R11 stalled load ok", {31'b0, f}, 32'h0);
    check(readCnt - rc == 2, "R11 reads under stall", readCnt - rc, 32'd2);
    check(readAddr[rc+1] == 32'h11C, "R11 high addr", readAddr[rc+1], 32'h11C);
    doAccess(32'hFF, 1'b0, 32'h00ABC0FF, 1'b0, 1'b1, "R9 read code");
    doAccess(32'h10, 1'b1, 32'h0, 1'b1, 1'b0, "R9 write code");

    // overrun: idx4 past global limit 0x1F
    rc = readCnt;
    loadSeg(16'h0022, f, 1'b0);
    check(f == 1'b1, "R5 overrun fault", {31'b0, f}, 32'h1);
    check(readCnt == rc, "R5 no reads", readCnt, rc);
    check(segRpl == 2'd0, "R5 rpl unchanged", {30'b0, segRpl}, 32'h0);
    doAccess(32'h5, 1'b0, 32'h00ABC005, 1'b0, 1'b1, "R5 old segment kept");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule